// File: doc/BRIEF.md
# Clock Frequency Measurement Checker

This block checks that a measured clock runs at the expected rate. It counts pulses on a tick input, one per measured-clock cycle, already brought into the block clock domain. The counting window is the interval between two pulses of a reference-window strobe that comes from a slow, always-running reference clock. When a window closes, the count is compared with a lower and an upper bound held outside the block. A count below the lower bound is slow. A count above the upper bound is fast. A count between the bounds is okay. A counter that runs past its range is always reported as fast.

Slow, fast and timeout errors each set a sticky flag and raise a single-cycle recoverable-alert pulse. Software clears a flag by writing a 1 to its clear bit. A timeout is raised when a run of consecutive windows passes with no tick at all. Such empty windows are not valid measurements and are never compared with the bounds.

A small state machine controls the block. `S_IDLE` is the state while the check is disabled. `S_ARM` waits for the first window strobe after the enable rises. `S_MEAS` counts and evaluates windows. The transitions are:
- `S_IDLE`→`S_ARM` when the enable goes high.
- `S_ARM`→`S_MEAS` on a window strobe.
- `S_ARM` or `S_MEAS` → `S_IDLE` whenever the enable is low.

Top module: `freq_meas_monitor`

## Requirements
- R1: After reset, all outputs (slow_o, fast_o, timeout_o, ok_o, alert_o) are 0 and the block is in S_IDLE.
- R2: After en_i rises, the first ref_win_i pulse only opens a window (S_ARM to S_MEAS). Ticks seen before it produce no result, no flag and no alert.
- R3: The count of a window is the number of cycles with meas_tick_i high after the opening strobe's cycle, up to and including the closing strobe's cycle. If the count is nonzero and lo_bound_i <= count <= hi_bound_i, ok_o pulses for one cycle, the cycle after the closing edge, with no alert.
- R4: A nonzero count below lo_bound_i sets slow_o. In the cycle after the closing edge, alert_o is 1.
- R5: A count above hi_bound_i sets fast_o. In the cycle after the closing edge, alert_o is 1.
- R6: The counter saturates at 2^CNT_W-1. One more tick in the same window sets an internal overflow flag, and the window is reported as fast even when hi_bound_i is at its maximum. A count of exactly 2^CNT_W-1 is not an overflow.
- R7: A window with zero ticks is not compared with the bounds. When TMO_WIN consecutive evaluated windows (default 4) are empty, timeout_o sets, alert_o pulses and the run restarts. Any nonempty window resets the run.
- R8: The flags are sticky. err_clr_i bit 0 clears slow_o, bit 1 clears fast_o and bit 2 clears timeout_o. If a set and a clear of the same flag fall in the same cycle, the flag stays set.
- R9: alert_o is high for exactly the cycle after each edge on which an error is detected, and is 0 otherwise.
- R10: While en_i is low the block returns to S_IDLE. The partial window and the empty-window run are discarded, and re-enabling arms again as in R2.
- R11: If lo_bound_i > hi_bound_i, a count that violates both bounds is reported as fast, not slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables measurement |
| lo_bound_i | input | CNT_W | Lowest acceptable count |
| hi_bound_i | input | CNT_W | Highest acceptable count |
| meas_tick_i | input | 1 | One pulse per measured-clock cycle, synchronized |
| ref_win_i | input | 1 | Reference window boundary strobe |
| err_clr_i | input | 3 | Write-1-to-clear: bit0 slow, bit1 fast, bit2 timeout |
| slow_o | output | 1 | Sticky slow error flag |
| fast_o | output | 1 | Sticky fast/overflow error flag |
| timeout_o | output | 1 | Sticky timeout error flag |
| ok_o | output | 1 | One-cycle pulse for an in-range window |
| alert_o | output | 1 | One-cycle recoverable alert pulse per error |

## Verification
The overflow path is the hardest case to reach from the ports. It needs more than 2^CNT_W-1 ticks inside a single window. The stimulus holds one window open for several hundred cycles with the tick held high, and checks both sides of the limit: exactly 2^CNT_W-1 ticks with the upper bound at its maximum, then one tick more. The timeout run needs a similar sequence. The bench drives empty windows, drops the enable partway through a run, and confirms that the run restarts from zero. Randomly sized windows and bounds, including inverted bounds, are mixed with randomly timed clears.

// File: rtl/freq_meas_pkg.sv
package freq_meas_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_MEAS = 2'd2
    } fm_state_e;

    typedef enum logic [1:0] {
        RES_EMPTY = 2'd0,
        RES_OK    = 2'd1,
        RES_SLOW  = 2'd2,
        RES_FAST  = 2'd3
    } fm_result_e;

    localparam int unsigned ERR_SLOW = 0;
    localparam int unsigned ERR_FAST = 1;
    localparam int unsigned ERR_TMO  = 2;
    localparam int unsigned ERR_N    = 3;

endpackage

// File: rtl/freq_meas_counter.sv
module freq_meas_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovfl_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovfl_q;
    logic             at_max;

    assign at_max = &cnt_q;

    // value including this cycle's tick; saturates at the top
    always_comb begin
        cnt_o  = (inc_i && !at_max) ? cnt_q + 1'b1 : cnt_q;
        ovfl_o = ovfl_q | (inc_i & at_max);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            ovfl_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q  <= '0;
            ovfl_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_o;
            ovfl_q <= ovfl_o;
        end
    end

endmodule

// File: rtl/freq_meas_classify.sv
module freq_meas_classify
    import freq_meas_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovfl_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output fm_result_e       res_o
);

    // priority: empty, then fast (overflow or above), then slow
    always_comb begin
        if (cnt_i == '0 && !ovfl_i) begin
            res_o = RES_EMPTY;
        end else if (ovfl_i || cnt_i > hi_i) begin
            res_o = RES_FAST;
        end else if (cnt_i < lo_i) begin
            res_o = RES_SLOW;
        end else begin
            res_o = RES_OK;
        end
    end

endmodule

// File: rtl/freq_meas_timeout.sv
module freq_meas_timeout #(
    parameter int unsigned TMO_WIN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic close_i,
    input  logic empty_i,
    output logic hit_o
);

    localparam int unsigned RUN_W = $clog2(TMO_WIN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TMO_WIN - 1);

    logic [RUN_W-1:0] run_q;

    assign hit_o = close_i & empty_i & (run_q == RUN_LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (clear_i) begin
            run_q <= '0;
        end else if (close_i) begin
            if (!empty_i || hit_o) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/freq_meas_monitor.sv
module freq_meas_monitor
    import freq_meas_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TMO_WIN = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] lo_bound_i,
    input  logic [CNT_W-1:0] hi_bound_i,
    input  logic             meas_tick_i,
    input  logic             ref_win_i,
    input  logic [ERR_N-1:0] err_clr_i,
    output logic             slow_o,
    output logic             fast_o,
    output logic             timeout_o,
    output logic             ok_o,
    output logic             alert_o
);

    fm_state_e        state_q, state_d;
    logic             counting, closing, cnt_clear, run_clear;
    logic [CNT_W-1:0] win_cnt;
    logic             win_ovfl;
    fm_result_e       win_res;
    logic             tmo_hit;
    logic [ERR_N-1:0] err_ev, err_q;
    logic             ok_ev;
    logic             alert_q, ok_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (en_i) state_d = S_ARM;
            S_ARM:   if (!en_i) state_d = S_IDLE;
                     else if (ref_win_i) state_d = S_MEAS;
            S_MEAS:  if (!en_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // state-decoded controls
    always_comb begin
        counting  = (state_q == S_MEAS) && en_i;
        closing   = counting && ref_win_i;
        cnt_clear = !counting || ref_win_i;
        run_clear = !counting;
    end

    freq_meas_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (cnt_clear),
        .inc_i   (counting & meas_tick_i),
        .cnt_o   (win_cnt),
        .ovfl_o  (win_ovfl)
    );

    freq_meas_classify #(.CNT_W(CNT_W)) u_cls (
        .cnt_i  (win_cnt),
        .ovfl_i (win_ovfl),
        .lo_i   (lo_bound_i),
        .hi_i   (hi_bound_i),
        .res_o  (win_res)
    );

    freq_meas_timeout #(.TMO_WIN(TMO_WIN)) u_tmo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (run_clear),
        .close_i (closing),
        .empty_i (win_res == RES_EMPTY),
        .hit_o   (tmo_hit)
    );

    always_comb begin
        err_ev           = '0;
        err_ev[ERR_SLOW] = closing && (win_res == RES_SLOW);
        err_ev[ERR_FAST] = closing && (win_res == RES_FAST);
        err_ev[ERR_TMO]  = tmo_hit;
        ok_ev            = closing && (win_res == RES_OK);
    end

    // sticky flags, set over clear
    for (genvar g = 0; g < ERR_N; g++) begin : g_flag
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) err_q[g] <= 1'b0;
            else         err_q[g] <= (err_q[g] & ~err_clr_i[g]) | err_ev[g];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            alert_q <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            alert_q <= |err_ev;
            ok_q    <= ok_ev;
        end
    end

    always_comb begin
        slow_o    = err_q[ERR_SLOW];
        fast_o    = err_q[ERR_FAST];
        timeout_o = err_q[ERR_TMO];
        ok_o      = ok_q;
        alert_o   = alert_q;
    end

endmodule

// File: rtl/freq_meas_monitor_chk.sv
module freq_meas_monitor_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       en_i,
    input logic [2:0] err_clr_i,
    input logic       slow_o,
    input logic       fast_o,
    input logic       timeout_o,
    input logic       ok_o,
    input logic       alert_o
);

    assert_slow_alert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(slow_o) |-> alert_o);

    assert_fast_alert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fast_o) |-> alert_o);

    assert_tmo_alert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> alert_o);

    assert_ok_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ok_o |-> !alert_o);

    assert_slow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slow_o && !err_clr_i[0]) |=> slow_o);

    assert_fast_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_o && !err_clr_i[1]) |=> fast_o);

    assert_tmo_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o && !err_clr_i[2]) |=> timeout_o);

    assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!alert_o && !ok_o));

endmodule

bind freq_meas_monitor freq_meas_monitor_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .err_clr_i (err_clr_i),
    .slow_o    (slow_o),
    .fast_o    (fast_o),
    .timeout_o (timeout_o),
    .ok_o      (ok_o),
    .alert_o   (alert_o)
);

// File: tb/freq_meas_monitor_tb.sv
module freq_meas_monitor_tb;

    localparam int CNT_W   = 8;
    localparam int TMO_WIN = 4;
    localparam int MAXC    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [CNT_W-1:0] lo = '0;
    logic [CNT_W-1:0] hi = '0;
    logic             tick = 1'b0;
    logic             refw = 1'b0;
    logic [2:0]       clr = '0;
    logic             slow, fast, tmo, ok, alert;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model state
    bit e_slow, e_fast, e_tmo;
    bit armed;
    int run;

    always #2 clk = ~clk;

    freq_meas_monitor #(.CNT_W(CNT_W), .TMO_WIN(TMO_WIN)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .lo_bound_i(lo), .hi_bound_i(hi),
        .meas_tick_i(tick), .ref_win_i(refw), .err_clr_i(clr),
        .slow_o(slow), .fast_o(fast), .timeout_o(tmo),
        .ok_o(ok), .alert_o(alert)
    );

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {slow,fast,tmo,ok,alert} actual %b expected %b", req, act, exp);
        end
    endtask

    // 0 empty, 1 ok, 2 slow, 3 fast
    function automatic int classify(int n, int l, int h);
        if (n == 0) return 0;
        if (n > MAXC || n > h) return 3;
        if (n < l) return 2;
        return 1;
    endfunction

    task automatic do_window(int n, int len, logic [2:0] clr_last);
        int  res;
        bit  ev_s, ev_f, ev_t, ev_ok;
        string tag;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tick = (i < n);
            refw = (i == len - 1);
            clr  = (i == len - 1) ? clr_last : 3'b000;
        end
        @(negedge clk);
        tick = 0; refw = 0; clr = 0;
        ev_s = 0; ev_f = 0; ev_t = 0; ev_ok = 0;
        tag = "R2";
        if (!armed) begin
            armed = 1;
        end else begin
            res = classify(n, int'(lo), int'(hi));
            if (res == 0) begin
                run++;
                tag = "R7";
                if (run == TMO_WIN) begin ev_t = 1; run = 0; end
            end else begin
                run = 0;
                ev_f  = (res == 3);
                ev_s  = (res == 2);
                ev_ok = (res == 1);
                tag = ev_ok ? "R3" : ev_s ? "R4" : (n > MAXC) ? "R6" :
                      (n < int'(lo)) ? "R11" : "R5";
            end
        end
        e_slow = (e_slow & ~clr_last[0]) | ev_s;
        e_fast = (e_fast & ~clr_last[1]) | ev_f;
        e_tmo  = (e_tmo  & ~clr_last[2]) | ev_t;
        if (clr_last != 0 && (ev_s | ev_f | ev_t)) tag = {tag, "/R8"};
        check(tag, {slow, fast, tmo, ok, alert},
              {e_slow, e_fast, e_tmo, ev_ok, ev_s | ev_f | ev_t});
    endtask

    task automatic clear_flags(logic [2:0] bits);
        @(negedge clk); clr = bits;
        @(negedge clk); clr = 0;
        e_slow &= ~bits[0]; e_fast &= ~bits[1]; e_tmo &= ~bits[2];
        check("R8", {slow, fast, tmo, ok, alert}, {e_slow, e_fast, e_tmo, 1'b0, 1'b0});
    endtask

    task automatic toggle_en();
        @(negedge clk); en = 0;
        @(negedge clk); en = 1;
        armed = 0; run = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        e_slow = 0; e_fast = 0; e_tmo = 0; armed = 0; run = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {slow, fast, tmo, ok, alert}, 5'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1", {slow, fast, tmo, ok, alert}, 5'b0);

        en = 1; lo = 8'd2; hi = 8'd3;
        // R2: arming window with ticks gives no result
        do_window(6, 8, 3'b000);
        do_window(3, 6, 3'b000);      // R3 ok
        do_window(1, 5, 3'b000);      // R4 slow
        @(negedge clk);
        check("R9", {1'b0, 1'b0, 1'b0, ok, alert}, 5'b0); // alert only one cycle
        do_window(5, 6, 3'b000);      // R5 fast
        clear_flags(3'b011);          // R8
        // R8: set and clear in the same cycle keeps the flag
        do_window(1, 4, 3'b001);
        clear_flags(3'b001);

        // R6: saturation boundary
        lo = 8'd1; hi = 8'(MAXC);
        do_window(MAXC, MAXC + 4, 3'b000);
        do_window(MAXC + 1, MAXC + 4, 3'b000);
        clear_flags(3'b010);

        // R11: inverted bounds
        lo = 8'd10; hi = 8'd4;
        do_window(6, 8, 3'b000);
        clear_flags(3'b111);

        // R7 / R10: empty run, interrupted by disable
        lo = 8'd1; hi = 8'd10;
        do_window(0, 4, 3'b000);
        do_window(0, 4, 3'b000);
        do_window(0, 4, 3'b000);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        toggle_en();
        check("R10", {slow, fast, tmo, ok, alert}, {e_slow, e_fast, e_tmo, 2'b00});
        do_window(0, 4, 3'b000);      // re-arm
        do_window(0, 4, 3'b000);
        do_window(0, 4, 3'b000);
        do_window(0, 4, 3'b000);      // R10: run restarted, no timeout yet
        do_window(0, 4, 3'b000);      // R7: fourth empty -> timeout
        do_window(2, 4, 3'b000);
        clear_flags(3'b100);

        // random windows
        for (int k = 0; k < 80; k++) begin
            int len = 2 + int'($urandom % 20);
            int n   = ($urandom % 4 == 0) ? 0 : int'($urandom % (len + 1));
            lo = 8'($urandom % 16);
            hi = 8'($urandom % 24);
            do_window(n, len, ($urandom % 5 == 0) ? 3'($urandom) : 3'b000);
            if ($urandom % 6 == 0) clear_flags(3'($urandom));
            if ($urandom % 15 == 0) begin
                toggle_en();
                do_window(int'($urandom % 3), 4, 3'b000);
            end
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule